// File: doc/BRIEF.md
# Line to Rectangle Run Generator

This block turns a straight line, given as two pixel endpoints, into a short stream of axis-aligned rectangle fill commands for a rectangle-filling frame store. The line is walked along its major axis, the one with the larger coordinate span. Every stretch of pixels that shares one minor-axis coordinate becomes a single rectangle, one pixel thick. A line therefore costs one command per minor-axis step plus one, not one per pixel. Horizontal and vertical lines collapse to a single command.

An endpoint pair is taken over a valid/ready handshake. Rectangles leave over a second valid/ready stream. Each rectangle carries its low corner and its high corner, both inclusive, and a flag on the final rectangle of the line. The generator holds one line at a time. It takes the next pair only after the last rectangle of the current line has been accepted downstream. Coordinates are unsigned, 12 bits wide by default.

Top module: `line_run_gen`

## Requirements
- R1: `line_ready` is high exactly when no line is in progress. A pair is taken on a clock edge where `line_valid` and `line_ready` are both high. `line_ready` stays low from that edge until the edge on which the rectangle flagged last is accepted. A `line_valid` pulse while `line_ready` is low is ignored.
- R2: A line emits exactly min(|dx|,|dy|)+1 rectangles, where dx and dy are the endpoint coordinate differences. `rect_last` is high on the final rectangle only.
- R3: A line with dx = 0 or dy = 0 emits one rectangle spanning both endpoints, one pixel thick.
- R4: Every rectangle satisfies `rect_x_lo` <= `rect_x_hi` and `rect_y_lo` <= `rect_y_hi`, for any line direction.
- R5: The major axis is x when |dx| >= |dy|, and y otherwise. Every rectangle has equal low and high minor-axis coordinates.
- R6: The walk starts at the endpoint with the smaller major coordinate, or at the first endpoint when the two are equal. At major offset j from that start, the pixel's minor offset toward the other endpoint is j*dmin/dmaj rounded to the nearest integer, with exact halves rounded down. Rectangles come out in increasing major order, one per distinct minor offset. Together they cover exactly these pixels, with no overlap.
- R7: While `rect_valid` is high and `rect_ready` is low, `rect_valid`, all corners and `rect_last` hold their values. At most one rectangle is accepted per clock.
- R8: Synchronous active-high `rst` forces `rect_valid` low and `line_ready` high on the next edge, including in the middle of a line.
- R9: A line with |dx| = |dy| emits |dx|+1 rectangles of size 1x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid | input | 1 | Endpoint pair offered |
| line_ready | output | 1 | Generator idle, pair can be taken |
| pa_x | input | 12 | First endpoint x |
| pa_y | input | 12 | First endpoint y |
| pb_x | input | 12 | Second endpoint x |
| pb_y | input | 12 | Second endpoint y |
| rect_valid | output | 1 | Rectangle offered |
| rect_ready | input | 1 | Consumer takes the rectangle |
| rect_x_lo | output | 12 | Low x corner, inclusive |
| rect_y_lo | output | 12 | Low y corner, inclusive |
| rect_x_hi | output | 12 | High x corner, inclusive |
| rect_y_hi | output | 12 | High y corner, inclusive |
| rect_last | output | 1 | Final rectangle of the line |

## Verification
The hardest case to reach from the ports is a run boundary that comes up while the previous rectangle is still stalled. In that case the walker must stop advancing without losing its error term or its run start. The stimulus reaches it by applying a pseudo-random `rect_ready` pattern on short-run lines: steep lines, diagonals and reversed directions. On those lines boundaries fall on nearly every step, so stalls and boundaries coincide often.

The exact-half rounding case is also covered. A shallow line is chosen whose error term lands exactly on the threshold, and its expected runs are computed from the closed-form rounding rule. A pulse on `line_valid` in the middle of a long line, followed by a quiet period, shows that the extra request is ignored.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } lrg_state_e;
endpackage

// File: rtl/lrg_absdiff.sv
module lrg_absdiff #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag
);
  always_comb begin
    if (b >= a) mag = b - a;
    else        mag = a - b;
  end
endmodule

// File: rtl/lrg_setup.sv
module lrg_setup #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] x0,
  input  logic [CW-1:0] y0,
  input  logic [CW-1:0] x1,
  input  logic [CW-1:0] y1,
  input  logic [CW-1:0] adx,
  input  logic [CW-1:0] ady,
  output logic          x_major,
  output logic [CW-1:0] maj_start,
  output logic [CW-1:0] maj_end,
  output logic [CW-1:0] min_start,
  output logic          min_down,
  output logic [CW-1:0] d_maj,
  output logic [CW-1:0] d_min
);
  logic [CW-1:0] p0_maj, p1_maj, p0_min, p1_min, min_end;
  logic          swap;

  always_comb begin
    x_major = (adx >= ady);
    p0_maj  = x_major ? x0 : y0;
    p1_maj  = x_major ? x1 : y1;
    p0_min  = x_major ? y0 : x0;
    p1_min  = x_major ? y1 : x1;
    d_maj   = x_major ? adx : ady;
    d_min   = x_major ? ady : adx;
    // walk toward increasing major coordinate; ties keep the first endpoint
    swap      = (p0_maj > p1_maj);
    maj_start = swap ? p1_maj : p0_maj;
    maj_end   = swap ? p0_maj : p1_maj;
    min_start = swap ? p1_min : p0_min;
    min_end   = swap ? p0_min : p1_min;
    min_down  = (min_end < min_start);
  end
endmodule

// File: rtl/lrg_walker.sv
module lrg_walker
  import lrg_pkg::*;
#(
  parameter int CW = 12,
  parameter int EW = CW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          x_major,
  input  logic [CW-1:0] maj_start,
  input  logic [CW-1:0] maj_end,
  input  logic [CW-1:0] min_start,
  input  logic          min_down,
  input  logic [CW-1:0] d_maj,
  input  logic [CW-1:0] d_min,
  input  logic          out_ready,
  output logic          busy,
  output logic          out_valid,
  output logic [CW-1:0] x_lo,
  output logic [CW-1:0] y_lo,
  output logic [CW-1:0] x_hi,
  output logic [CW-1:0] y_hi,
  output logic          last
);
  localparam int PADW = EW - CW;

  lrg_state_e           state;
  logic                 xmaj_q, down_q;
  logic [CW-1:0]        cur_maj, run_start, end_q, cur_min, dmaj_q;
  logic signed [EW-1:0] err, dmin2_q;
  logic signed [EW-1:0] err_sum, dmaj_ext, dmaj2_ext;
  logic                 at_end, over, brk, slot_free, step;

  always_comb begin
    dmaj_ext  = $signed({{PADW{1'b0}}, dmaj_q});
    dmaj2_ext = $signed({{(PADW-1){1'b0}}, dmaj_q, 1'b0});
    err_sum   = err + dmin2_q;
    at_end    = (cur_maj == end_q);
    over      = (err_sum > dmaj_ext);
    brk       = at_end || over;
    slot_free = !out_valid || out_ready;
    step      = (state == ST_WALK) && (slot_free || !brk);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      last      <= 1'b0;
      x_lo      <= '0;
      y_lo      <= '0;
      x_hi      <= '0;
      y_hi      <= '0;
      xmaj_q    <= 1'b0;
      down_q    <= 1'b0;
      cur_maj   <= '0;
      run_start <= '0;
      end_q     <= '0;
      cur_min   <= '0;
      dmaj_q    <= '0;
      dmin2_q   <= '0;
      err       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            xmaj_q    <= x_major;
            down_q    <= min_down;
            cur_maj   <= maj_start;
            run_start <= maj_start;
            end_q     <= maj_end;
            cur_min   <= min_start;
            dmaj_q    <= d_maj;
            dmin2_q   <= $signed({{(PADW-1){1'b0}}, d_min, 1'b0});
            err       <= '0;
            state     <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (slot_free) out_valid <= brk;
          if (step) begin
            if (brk) begin
              x_lo <= xmaj_q ? run_start : cur_min;
              y_lo <= xmaj_q ? cur_min   : run_start;
              x_hi <= xmaj_q ? cur_maj   : cur_min;
              y_hi <= xmaj_q ? cur_min   : cur_maj;
              last <= at_end;
            end
            if (at_end) begin
              state <= ST_DRAIN;
            end else begin
              cur_maj <= cur_maj + CW'(1);
              if (over) begin
                err       <= err_sum - dmaj2_ext;
                cur_min   <= down_q ? cur_min - CW'(1) : cur_min + CW'(1);
                run_start <= cur_maj + CW'(1);
              end else begin
                err <= err_sum;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(x_lo) && $stable(y_lo)
      && $stable(x_hi) && $stable(y_hi) && $stable(last));

  // R4
  corner_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (x_lo <= x_hi) && (y_lo <= y_hi));

  // R5
  thin_rect_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (x_lo == x_hi) || (y_lo == y_hi));

  // R2
  last_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> out_valid && last);

  // R6
  minor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK) && $past(state == ST_WALK) && !$stable(cur_min)
      |-> $past(step) && (run_start == cur_maj));
endmodule

// File: rtl/line_run_gen.sv
module line_run_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_valid,
  output logic          line_ready,
  input  logic [CW-1:0] pa_x,
  input  logic [CW-1:0] pa_y,
  input  logic [CW-1:0] pb_x,
  input  logic [CW-1:0] pb_y,
  output logic          rect_valid,
  input  logic          rect_ready,
  output logic [CW-1:0] rect_x_lo,
  output logic [CW-1:0] rect_y_lo,
  output logic [CW-1:0] rect_x_hi,
  output logic [CW-1:0] rect_y_hi,
  output logic          rect_last
);
  localparam int NAX = 2;

  logic [CW-1:0] lo_pt [NAX];
  logic [CW-1:0] hi_pt [NAX];
  logic [CW-1:0] span  [NAX];
  logic          x_major, min_down, busy, load;
  logic [CW-1:0] maj_start, maj_end, min_start, d_maj, d_min;

  assign lo_pt[0] = pa_x;
  assign lo_pt[1] = pa_y;
  assign hi_pt[0] = pb_x;
  assign hi_pt[1] = pb_y;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    lrg_absdiff #(.W(CW)) u_diff (
      .a   (lo_pt[g]),
      .b   (hi_pt[g]),
      .mag (span[g])
    );
  end

  lrg_setup #(.CW(CW)) u_setup (
    .x0        (pa_x),
    .y0        (pa_y),
    .x1        (pb_x),
    .y1        (pb_y),
    .adx       (span[0]),
    .ady       (span[1]),
    .x_major   (x_major),
    .maj_start (maj_start),
    .maj_end   (maj_end),
    .min_start (min_start),
    .min_down  (min_down),
    .d_maj     (d_maj),
    .d_min     (d_min)
  );

  assign line_ready = !busy;
  assign load       = line_valid && line_ready;

  lrg_walker #(.CW(CW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .x_major   (x_major),
    .maj_start (maj_start),
    .maj_end   (maj_end),
    .min_start (min_start),
    .min_down  (min_down),
    .d_maj     (d_maj),
    .d_min     (d_min),
    .out_ready (rect_ready),
    .busy      (busy),
    .out_valid (rect_valid),
    .x_lo      (rect_x_lo),
    .y_lo      (rect_y_lo),
    .x_hi      (rect_x_hi),
    .y_hi      (rect_y_hi),
    .last      (rect_last)
  );

  // R1
  accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rect_valid |-> !line_ready);

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_ready) |-> $past(line_valid));
endmodule

// File: tb/tb_line_run_gen.sv
`timescale 1ns/1ps
module tb_line_run_gen;
  localparam int CW = 12;
  localparam int NV = 10;
  // {pa_x, pa_y, pb_x, pb_y, expected rectangle count}
  localparam logic [63:0] VEC [NV] = '{
    {12'd10,  12'd20,   12'd30,   12'd20,   16'd1},
    {12'd5,   12'd100,  12'd5,    12'd40,   16'd1},
    {12'd0,   12'd0,    12'd6,    12'd6,    16'd7},
    {12'd0,   12'd0,    12'd10,   12'd3,    16'd4},
    {12'd40,  12'd10,   12'd2,    12'd25,   16'd16},
    {12'd100, 12'd200,  12'd103,  12'd180,  16'd4},
    {12'd7,   12'd7,    12'd7,    12'd7,    16'd1},
    {12'd0,   12'd4095, 12'd4095, 12'd4092, 16'd4},
    {12'd300, 12'd300,  12'd301,  12'd310,  16'd2},
    {12'd50,  12'd60,   12'd20,   12'd30,   16'd31}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_valid = 1'b0, line_ready;
  logic [CW-1:0] pa_x = '0, pa_y = '0, pb_x = '0, pb_y = '0;
  logic rect_valid, rect_ready = 1'b1, rect_last;
  logic [CW-1:0] rect_x_lo, rect_y_lo, rect_x_hi, rect_y_hi;

  always #2.5 clk = ~clk;

  line_run_gen #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .line_valid(line_valid), .line_ready(line_ready),
    .pa_x(pa_x), .pa_y(pa_y), .pb_x(pb_x), .pb_y(pb_y),
    .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_x_lo(rect_x_lo), .rect_y_lo(rect_y_lo),
    .rect_x_hi(rect_x_hi), .rect_y_hi(rect_y_hi), .rect_last(rect_last)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [47:0] exp_rect [4096];
  int exp_n;
  string exp_tag;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic push_run(input bit xm, input int a, input int b, input int c);
    if (xm) exp_rect[exp_n] = {CW'(a), CW'(c), CW'(b), CW'(c)};
    else    exp_rect[exp_n] = {CW'(c), CW'(a), CW'(c), CW'(b)};
    exp_n++;
  endtask

  // expected runs from the closed-form rounding rule of R6
  task automatic compute_exp(input int ax, input int ay, input int bx, input int by);
    int adx, ady, dmaj, dmin, sm, smin, emin, dir, run_s, prev_m, m;
    int p0m, p1m, p0n, p1n;
    bit xm;
    adx = (bx > ax) ? bx - ax : ax - bx;
    ady = (by > ay) ? by - ay : ay - by;
    xm  = (adx >= ady);
    p0m = xm ? ax : ay;  p1m = xm ? bx : by;
    p0n = xm ? ay : ax;  p1n = xm ? by : bx;
    dmaj = xm ? adx : ady;
    dmin = xm ? ady : adx;
    if (p0m > p1m) begin sm = p1m; smin = p1n; emin = p0n; end
    else           begin sm = p0m; smin = p0n; emin = p1n; end
    dir = (emin < smin) ? -1 : 1;
    if (adx == 0 || ady == 0) exp_tag = "R3";
    else if (adx == ady)      exp_tag = "R9";
    else                      exp_tag = "R6";
    exp_n = 0; run_s = sm; prev_m = 0;
    for (int j = 0; j <= dmaj; j++) begin
      m = (dmaj == 0) ? 0 : (2 * j * dmin + dmaj - 1) / (2 * dmaj);
      if (j > 0 && m != prev_m) begin
        push_run(xm, run_s, sm + j - 1, smin + dir * prev_m);
        run_s = sm + j;
      end
      prev_m = m;
    end
    push_run(xm, run_s, sm + dmaj, smin + dir * prev_m);
  endtask

  task automatic run_line(input int ax, input int ay, input int bx, input int by,
                          input int cnt, input bit rnd, input bit poke);
    int got, cycles;
    bit done, held, rr;
    logic [47:0] saved, cur;
    compute_exp(ax, ay, bx, by);
    check(exp_n == cnt, {"R2 table count ", exp_tag}, exp_n, cnt);
    @(negedge clk);
    check(line_ready == 1'b1, "R1 ready when idle", line_ready, 1);
    line_valid = 1'b1;
    pa_x = CW'(ax); pa_y = CW'(ay); pb_x = CW'(bx); pb_y = CW'(by);
    @(negedge clk);
    line_valid = 1'b0;
    check(line_ready == 1'b0, "R1 busy after accept", line_ready, 0);
    got = 0; done = 0; held = 0; cycles = 0; saved = '0;
    while (!done) begin
      cur = {rect_x_lo, rect_y_lo, rect_x_hi, rect_y_hi};
      if (held) check(rect_valid && cur == saved, "R7 stalled output held", cur, saved);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rr = rnd ? (lfsr[1:0] != 2'b00) : 1'b1;
      if (poke && cycles == 2) begin
        line_valid = 1'b1;
        pa_x = 12'd1; pa_y = 12'd2; pb_x = 12'd3; pb_y = 12'd900;
      end else line_valid = 1'b0;
      rect_ready = rr;
      if (rect_valid) begin
        if (rr) begin
          if (got < exp_n) begin
            check(cur == exp_rect[got], {"R6 rect ", exp_tag}, cur, exp_rect[got]);
            check(rect_last == (got == exp_n - 1), "R2 last flag", rect_last, got == exp_n - 1);
            check(rect_x_lo <= rect_x_hi && rect_y_lo <= rect_y_hi, "R4 ordered", cur, exp_rect[got]);
            check(rect_x_lo == rect_x_hi || rect_y_lo == rect_y_hi, "R5 thin", cur, exp_rect[got]);
          end else check(1'b0, "R2 extra rect", got, exp_n);
          got++;
          if (rect_last) done = 1;
          held = 0;
        end else begin
          held = 1; saved = cur;
        end
      end else held = 0;
      @(negedge clk);
      cycles++;
    end
    line_valid = 1'b0;
    rect_ready = 1'b1;
    check(got == exp_n, {"R2 count ", exp_tag}, got, exp_n);
    check(line_ready == 1'b1, "R1 ready after last", line_ready, 1);
    check(rect_valid == 1'b0, "R1 no rect after last", rect_valid, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      check(rect_valid == 1'b0 && line_ready == 1'b1, "R1 busy pulse ignored", rect_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rect_valid == 1'b0, "R8 reset valid", rect_valid, 0);
    check(line_ready == 1'b1, "R8 reset ready", line_ready, 1);

    for (int i = 0; i < NV; i++) begin
      run_line(int'(VEC[i][63:52]), int'(VEC[i][51:40]), int'(VEC[i][39:28]),
               int'(VEC[i][27:16]), int'(VEC[i][15:0]), (i % 2) == 1, 1'b0);
    end

    // R7: heavy backpressure on short-run lines
    run_line(0, 0, 6, 6, 7, 1'b1, 1'b0);
    run_line(300, 300, 301, 310, 2, 1'b1, 1'b0);
    run_line(900, 20, 880, 43, 21, 1'b1, 1'b0);

    // R1: request while busy on a long line
    run_line(0, 500, 2000, 505, 6, 1'b0, 1'b1);

    // R8: reset in the middle of a line
    @(negedge clk);
    line_valid = 1'b1;
    pa_x = 12'd0; pa_y = 12'd0; pb_x = 12'd400; pb_y = 12'd9;
    @(negedge clk);
    line_valid = 1'b0;
    rect_ready = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rect_ready = 1'b1;
    check(rect_valid == 1'b0, "R8 mid-line reset valid", rect_valid, 0);
    check(line_ready == 1'b1, "R8 mid-line reset ready", line_ready, 1);
    run_line(20, 5, 5, 20, 16, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule